// File: doc/BRIEF.md
# Coprocessor Error Interrupt Handler

This block handles the floating-point error handshake of a legacy processor. The processor's active-low error line comes in through a synchronizer. While the function is enabled, an active error raises interrupt request 13, which feeds the processor's interrupt output through the system's interrupt controller.

Software clears the condition by writing a fixed I/O port. That write drops the request and pulls an active-low ignore-error line back to the processor. The line stays low for as long as the error input stays active. Once the error input returns inactive, the block goes back to idle and is ready for the next error.

A single enable bit, taken from a control register elsewhere, switches the whole function on or off. While it is off, the state machine is held idle and both outputs stay inactive.

Top module: `fpu_err_handler`

## Requirements
- R1: The reset (rst_ni low, asynchronous) drives irq13_o to 0 and ignne_no to 1 and places the block in idle.
- R2: With enable_i at 1 in idle, a low level on fpu_err_ni sets irq13_o to 1 on the third rising clock edge after the level is applied. Two of those edges are the synchronizer stages.
- R3: While irq13_o is 1, a clear write moves the block to ignoring state at the next edge: irq13_o becomes 0 and ignne_no becomes 0. A clear write is io_wr_i at 1 with io_addr_i equal to 16'h00F0 on all 16 bits.
- R4: In ignoring state, ignne_no stays 0 while fpu_err_ni stays low, and further clear writes have no effect. After fpu_err_ni returns high, ignne_no returns to 1 on the third rising edge.
- R5: ignne_no is 0 only if the synchronized error was active in the previous cycle. irq13_o and a low ignne_no never occur together.
- R6: A clear write in idle has no effect: both outputs hold their values, and a later error raises irq13_o in the normal way.
- R7: In the pending state, a write to any other address, or a read of address 16'h00F0 (io_wr_i at 0), leaves irq13_o at 1 and ignne_no at 1.
- R8: If fpu_err_ni returns high while irq13_o is 1, irq13_o returns to 0 on the third edge and the block is back in idle. The release wins over a clear write that arrives in that same cycle.
- R9: With enable_i at 0, both outputs are inactive after the next edge and stay inactive, whatever fpu_err_ni and the writes do. After enable_i returns to 1 with the error still active, irq13_o rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Function enable bit from the control register |
| fpu_err_ni | input | 1 | Processor floating-point error, active low, asynchronous |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_addr_i | input | 16 | I/O address of the current access |
| irq13_o | output | 1 | Interrupt request 13 toward the interrupt controller |
| ignne_no | output | 1 | Ignore-error line to the processor, active low |

## Verification
A state machine stuck in pending shows up as irq13_o held high after the clear write, visible one edge after the write. A state machine that falls through to idle too early shows as ignne_no going high while fpu_err_ni is still low. A wrong synchronizer depth moves the rising edge of irq13_o away from the third edge after the error, so every check is timed to the exact edge. A missed release shows as ignne_no held low three edges after the error clears.

// File: rtl/fpu_err_pkg.sv
package fpu_err_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_IGN  = 2'd2
  } fe_state_e;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_ni,
  output logic err_act_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b1;
          else         sync_q[0] <= err_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b1;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign err_act_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/fe_port_decode.sv
module fe_port_decode #(
  parameter int unsigned      ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CLR_PORT = 'h00F0
) (
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              clr_hit_o
);
  // full decode: aliases of the port must not clear the error
  assign clr_hit_o = io_wr_i && (io_addr_i == CLR_PORT);
endmodule

// File: rtl/fe_fsm.sv
module fe_fsm
  import fpu_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic err_act_i,
  input  logic clr_hit_i,
  output logic irq13_o,
  output logic ignne_no
);
  fe_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (err_act_i) state_d = ST_PEND;
        // release has priority over a clear write in the same cycle
        ST_PEND: if (!err_act_i)     state_d = ST_IDLE;
                 else if (clr_hit_i) state_d = ST_IGN;
        ST_IGN:  if (!err_act_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      irq13_o  <= 1'b0;
      ignne_no <= 1'b1;
    end else begin
      state_q  <= state_d;
      irq13_o  <= (state_d == ST_PEND);
      ignne_no <= (state_d != ST_IGN);
    end
  end

  AST_IGN_NEEDS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ignne_no |-> $past(err_act_i)) else $error("ignne without error"); // R5
  AST_OUT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq13_o && !ignne_no)) else $error("irq and ignne together"); // R5
  AST_CLR_SWAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq13_o && clr_hit_i && err_act_i && enable_i) |=> (!irq13_o && !ignne_no))
    else $error("clear write did not swap"); // R3
  AST_IDLE_CLR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq13_o && ignne_no && clr_hit_i) |=> ignne_no)
    else $error("clear write in idle acted"); // R6
  AST_RELEASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_act_i |=> (!irq13_o && ignne_no)) else $error("no release"); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!irq13_o && ignne_no)) else $error("active while disabled"); // R9
endmodule

// File: rtl/fpu_err_handler.sv
module fpu_err_handler #(
  parameter int unsigned      ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CLR_PORT    = 'h00F0,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              fpu_err_ni,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              irq13_o,
  output logic              ignne_no
);
  logic err_act, clr_hit;

  fe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_ni(fpu_err_ni), .err_act_o(err_act)
  );

  fe_port_decode #(.ADDR_W(ADDR_W), .CLR_PORT(CLR_PORT)) i_dec (
    .io_wr_i(io_wr_i), .io_addr_i(io_addr_i), .clr_hit_o(clr_hit)
  );

  fe_fsm i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .err_act_i(err_act), .clr_hit_i(clr_hit),
    .irq13_o(irq13_o), .ignne_no(ignne_no)
  );
endmodule

// File: tb/test_fpu_err_handler.sv
module test_fpu_err_handler;
  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b1, err_n = 1'b1, wr = 1'b0;
  logic [15:0] addr = 16'h0;
  logic irq, ign_n;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpu_err_handler i_fpu_err_handler (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(en), .fpu_err_ni(err_n),
    .io_wr_i(wr), .io_addr_i(addr), .irq13_o(irq), .ignne_no(ign_n)
  );

  // {en, err_n, wr, addr[15:0], cycles[3:0], exp_irq, exp_ign_n, req[5:0]}
  localparam int NV = 25;
  localparam logic [30:0] VEC [NV] = '{
    {3'b110, 16'h0000, 4'd3, 2'b01, 6'd1},  // R1 idle
    {3'b100, 16'h0000, 4'd2, 2'b01, 6'd2},  // R2 not yet
    {3'b100, 16'h0000, 4'd1, 2'b11, 6'd2},  // R2 third edge
    {3'b101, 16'h00F1, 4'd1, 2'b11, 6'd7},  // R7 other port
    {3'b100, 16'h00F0, 4'd1, 2'b11, 6'd7},  // R7 read
    {3'b101, 16'h10F0, 4'd1, 2'b11, 6'd7},  // R7 upper bits
    {3'b101, 16'h00F0, 4'd1, 2'b00, 6'd3},  // R3 clear write
    {3'b101, 16'h00F0, 4'd1, 2'b00, 6'd4},  // R4 repeat write
    {3'b100, 16'h0000, 4'd4, 2'b00, 6'd4},  // R4 hold
    {3'b110, 16'h0000, 4'd2, 2'b00, 6'd4},  // R4 sync lag
    {3'b110, 16'h0000, 4'd1, 2'b01, 6'd4},  // R4 released
    {3'b111, 16'h00F0, 4'd1, 2'b01, 6'd6},  // R6 idle write
    {3'b110, 16'h0000, 4'd3, 2'b01, 6'd6},
    {3'b100, 16'h0000, 4'd3, 2'b11, 6'd6},  // R6 normal irq after
    {3'b110, 16'h0000, 4'd2, 2'b11, 6'd8},  // R8 lag
    {3'b110, 16'h0000, 4'd1, 2'b01, 6'd8},  // R8 dropped
    {3'b111, 16'h00F0, 4'd1, 2'b01, 6'd8},  // R8 idle again
    {3'b100, 16'h0000, 4'd3, 2'b11, 6'd2},
    {3'b000, 16'h0000, 4'd1, 2'b01, 6'd9},  // R9 disable
    {3'b001, 16'h00F0, 4'd1, 2'b01, 6'd9},
    {3'b000, 16'h0000, 4'd3, 2'b01, 6'd9},
    {3'b100, 16'h0000, 4'd1, 2'b11, 6'd9},  // R9 re-enable
    {3'b101, 16'h00F0, 4'd1, 2'b00, 6'd3},
    {3'b000, 16'h0000, 4'd1, 2'b01, 6'd9},  // R9 disable from ignoring
    {3'b110, 16'h0000, 4'd4, 2'b01, 6'd1}
  };

  task automatic check(input logic ei, input logic en_n, input int req);
    n_chk++;
    if (irq !== ei || ign_n !== en_n) begin
      n_fail++;
      $display("FAIL R%0d: irq13_o=%b ignne_no=%b expected %b %b", req, irq, ign_n, ei, en_n);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(2);
    check(1'b0, 1'b1, 1); // R1 during reset
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {en, err_n, wr, addr} = VEC[i][30:12];
      cyc(int'(VEC[i][11:8]));
      check(VEC[i][7], VEC[i][6], int'(VEC[i][5:0]));
    end
    wr = 1'b0;
    // R8 release wins over a same-cycle clear write
    en = 1'b1; err_n = 1'b0; cyc(3);
    check(1'b1, 1'b1, 2);
    err_n = 1'b1; cyc(2);
    wr = 1'b1; addr = 16'h00F0; cyc(1);
    wr = 1'b0;
    check(1'b0, 1'b1, 8);
    // R1 asynchronous reset out of ignoring state
    err_n = 1'b0; cyc(3);
    wr = 1'b1; cyc(1); wr = 1'b0;
    check(1'b0, 1'b0, 3);
    #1 rst_ni = 1'b0; #1;
    check(1'b0, 1'b1, 1);
    @(negedge clk); rst_ni = 1'b1;
    cyc(2); check(1'b0, 1'b1, 2);
    cyc(1); check(1'b1, 1'b1, 2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: done=%b expected 1", done);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule